// File: doc/BRIEF.md
# Two-Wire Bus Recovery Sequencer

This block sits on the controller side of a two-wire serial bus. A slave can be left holding the data line low after an aborted transfer, a power loss or a reset. When that happens, the block frees the bus. A single-cycle request starts the routine. The block first takes the clock line low and releases the data line. It then sends clock pulses one at a time. During each high phase it looks at the data line. At the first pulse where data reads high, it stops clocking and creates a START condition. It then reports completion, so a normal transfer can follow at once.

Both lines are open-drain. The block only ever outputs "pull low" enables. A released line is expected to float high through its pull-up. Both lines are read back through a parameterised synchroniser. Each clock phase lasts at least one half period from an internal divider. A high phase is only timed once the clock line really reads high, so a slave that stretches the clock just delays the sequence. If data is still low after the last allowed pulse, the block gives up. It releases both lines, raises a failure flag and still reports completion.

Top module: `twi_bus_recover`

## Requirements
- R1: While reset is asserted and right after it, neither line is pulled, and busy_o, done_o, fail_o and pulses_o are all 0.
- R2: A request seen while idle makes busy_o high on the next cycle. busy_o stays high until the cycle in which done_o is high. done_o is high for exactly one cycle per sequence, and busy_o is low in that cycle.
- R3: One sequence produces at most MAX_PULSES (default 9) rising edges on the clock line, and pulses_o never exceeds MAX_PULSES.
- R4: The data line is sampled once per high phase, at the end of that phase. Clocking stops at the first pulse where data reads high. If a slave lets go after its K-th falling clock edge, the sequence makes K+1 pulses, and pulses_o reports that number from done_o onward.
- R5: On success the block pulls the data line low while the clock line is released and high. The clock line stays released for at least a half period after that and from then on. This is exactly one high-to-low data transition with the clock high.
- R6: Apart from the START, the data-line pull changes only while the block pulls the clock line low. A data-line release with the clock high (a STOP) never happens.
- R7: If data is still low in the high phase of pulse MAX_PULSES, the block asserts fail_o together with done_o. It then releases both lines, and pulses_o equals MAX_PULSES.
- R8: Every low phase of the clock line that the block drives, and every high phase inside a sequence, lasts at least HALF_DIV clock cycles.
- R9: After releasing the clock line, the block waits for the line to read high before it times the high phase. Holding the clock low externally (stretching) lengthens the low phase but does not change the pulse count or the result.
- R10: After a successful sequence, the data-line pull (SDA low, clock high) is held until the next request. A new request first pulls the clock line low while keeping the data pull. It releases the data pull only after that, so no STOP is produced.
- R11: A request that arrives while a sequence is running is ignored. There is still exactly one done_o pulse, and the pulse count is unchanged.
- R12: fail_o and pulses_o keep their values after done_o until the next accepted request. fail_o is cleared when that request is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| recover_req_i | input | 1 | Start a recovery sequence (used only while idle) |
| scl_in_i | input | 1 | Level read back from the clock line |
| sda_in_i | input | 1 | Level read back from the data line |
| scl_pull_o | output | 1 | 1 = pull the clock line low, 0 = release it |
| sda_pull_o | output | 1 | 1 = pull the data line low, 0 = release it |
| busy_o | output | 1 | A sequence is in progress |
| done_o | output | 1 | One-cycle pulse when a sequence ends |
| fail_o | output | 1 | Last sequence ended with data still low |
| pulses_o | output | CNT_W ($clog2(MAX_PULSES+1)) | Clock pulses issued by the current or last sequence |

## Verification
The hardest cases to reach are at the pulse limit: a slave that lets go during the low phase before the ninth pulse must give success, and one that holds one pulse longer must give failure. Both of these must also hold while the clock is being stretched and while SDA is still held low by a previous START. The bench models the slave directly. It holds the data line until it has counted a chosen number of falling clock edges, and it stretches every low phase by a chosen number of cycles. Directed runs cover release counts 8 and 9 and a permanently stuck slave. Seeded random runs mix release counts, stretch lengths and stray mid-sequence requests, and they start from whatever line state the previous run left.

// File: rtl/twr_pkg.sv
package twr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_PREP  = 3'd1,
        ST_LOW   = 3'd2,
        ST_RISE  = 3'd3,
        ST_HIGH  = 3'd4,
        ST_START = 3'd5
    } twr_state_e;

    typedef struct packed {
        twr_state_e state;
        logic       scl_pull;
        logic       sda_pull;
        logic       done;
        logic       fail;
        logic       ph_new;
    } twr_regs_t;

    localparam twr_regs_t TWR_REGS_RST = '{
        state:    ST_IDLE,
        scl_pull: 1'b0,
        sda_pull: 1'b0,
        done:     1'b0,
        fail:     1'b0,
        ph_new:   1'b0
    };

endpackage

// File: rtl/twr_line_sync.sv
module twr_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic line_o
);

    generate
        if (STAGES == 0) begin : g_bypass
            assign line_o = line_i;
        end else begin : g_chain
            logic [STAGES-1:0] chain_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    chain_q[0] <= 1'b1;
                end else begin
                    chain_q[0] <= line_i;
                end
            end
            for (genvar i = 1; i < STAGES; i++) begin : g_stage
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) begin
                        chain_q[i] <= 1'b1;
                    end else begin
                        chain_q[i] <= chain_q[i-1];
                    end
                end
            end
            assign line_o = chain_q[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/twr_half_timer.sv
module twr_half_timer #(
    parameter int HALF_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart_i,
    output logic tick_o
);

    localparam int DIV_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [DIV_W-1:0] LAST = DIV_W'(HALF_DIV - 1);

    logic [DIV_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (restart_i) begin
            cnt_d = '0;
        end else if (cnt_q == LAST) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    // The first cycle of a phase never ticks, so a phase lasts HALF_DIV+1 cycles.
    assign tick_o = !restart_i && (cnt_q == LAST);

endmodule

// File: rtl/twr_pulse_ctr.sv
module twr_pulse_ctr #(
    parameter int MAX_PULSES = 9,
    parameter int CNT_W      = $clog2(MAX_PULSES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             inc_i,
    output logic [CNT_W-1:0] count_o,
    output logic             last_o
);

    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(MAX_PULSES);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i) begin
            cnt_d = '0;
        end else if (inc_i && (cnt_q != LIMIT)) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign count_o = cnt_q;
    assign last_o  = (cnt_q == LIMIT);

endmodule

// File: rtl/twi_bus_recover.sv
module twi_bus_recover
    import twr_pkg::*;
#(
    parameter int HALF_DIV    = 4,
    parameter int MAX_PULSES  = 9,
    parameter int SYNC_STAGES = 2,
    parameter int CNT_W       = $clog2(MAX_PULSES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             recover_req_i,
    input  logic             scl_in_i,
    input  logic             sda_in_i,
    output logic             scl_pull_o,
    output logic             sda_pull_o,
    output logic             busy_o,
    output logic             done_o,
    output logic             fail_o,
    output logic [CNT_W-1:0] pulses_o
);

    localparam int N_LINES = 2;
    localparam int IDX_SCL = 0;
    localparam int IDX_SDA = 1;

    logic [N_LINES-1:0] line_raw;
    logic [N_LINES-1:0] line_seen;

    assign line_raw[IDX_SCL] = scl_in_i;
    assign line_raw[IDX_SDA] = sda_in_i;

    generate
        for (genvar g = 0; g < N_LINES; g++) begin : g_sync
            twr_line_sync #(
                .STAGES (SYNC_STAGES)
            ) u_sync (
                .clk    (clk),
                .rst_n  (rst_n),
                .line_i (line_raw[g]),
                .line_o (line_seen[g])
            );
        end
    endgenerate

    twr_regs_t r_d, r_q;
    logic      tick;
    logic      cnt_clr, cnt_inc, cnt_last;
    logic [CNT_W-1:0] cnt_val;

    twr_half_timer #(
        .HALF_DIV (HALF_DIV)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (r_q.ph_new),
        .tick_o    (tick)
    );

    twr_pulse_ctr #(
        .MAX_PULSES (MAX_PULSES),
        .CNT_W      (CNT_W)
    ) u_pulses (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (cnt_clr),
        .inc_i   (cnt_inc),
        .count_o (cnt_val),
        .last_o  (cnt_last)
    );

    always_comb begin
        r_d     = r_q;
        r_d.done = 1'b0;
        cnt_clr = 1'b0;
        cnt_inc = 1'b0;
        unique case (r_q.state)
            ST_IDLE: begin
                if (recover_req_i) begin
                    // Clock goes low first; any held data pull stays for now.
                    r_d.state    = ST_PREP;
                    r_d.scl_pull = 1'b1;
                    r_d.fail     = 1'b0;
                    cnt_clr      = 1'b1;
                end
            end
            ST_PREP: begin
                if (tick) begin
                    r_d.state    = ST_LOW;
                    r_d.sda_pull = 1'b0;
                end
            end
            ST_LOW: begin
                if (tick) begin
                    r_d.state    = ST_RISE;
                    r_d.scl_pull = 1'b0;
                end
            end
            ST_RISE: begin
                if (line_seen[IDX_SCL]) begin
                    r_d.state = ST_HIGH;
                    cnt_inc   = 1'b1;
                end
            end
            ST_HIGH: begin
                if (tick) begin
                    if (line_seen[IDX_SDA]) begin
                        r_d.state    = ST_START;
                        r_d.sda_pull = 1'b1;
                    end else if (cnt_last) begin
                        r_d.state = ST_IDLE;
                        r_d.done  = 1'b1;
                        r_d.fail  = 1'b1;
                    end else begin
                        r_d.state    = ST_LOW;
                        r_d.scl_pull = 1'b1;
                    end
                end
            end
            ST_START: begin
                if (tick) begin
                    r_d.state = ST_IDLE;
                    r_d.done  = 1'b1;
                end
            end
            default: begin
                r_d = TWR_REGS_RST;
            end
        endcase
        r_d.ph_new = (r_d.state != r_q.state);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= TWR_REGS_RST;
        end else begin
            r_q <= r_d;
        end
    end

    assign scl_pull_o = r_q.scl_pull;
    assign sda_pull_o = r_q.sda_pull;
    assign busy_o     = (r_q.state != ST_IDLE);
    assign done_o     = r_q.done;
    assign fail_o     = r_q.fail;
    assign pulses_o   = cnt_val;

endmodule

// File: rtl/twr_checks.sv
module twr_checks #(
    parameter int HALF_DIV   = 4,
    parameter int MAX_PULSES = 9,
    parameter int CNT_W      = $clog2(MAX_PULSES + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             scl_pull_o,
    input logic             sda_pull_o,
    input logic             busy_o,
    input logic             done_o,
    input logic             fail_o,
    input logic [CNT_W-1:0] pulses_o
);

    logic [15:0] lo_run, hi_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_run <= '0;
            hi_run <= '0;
        end else begin
            lo_run <= scl_pull_o ? ((lo_run == 16'hFFFF) ? lo_run : lo_run + 16'd1) : 16'd0;
            hi_run <= !scl_pull_o ? ((hi_run == 16'hFFFF) ? hi_run : hi_run + 16'd1) : 16'd0;
        end
    end

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R2

    AST_BUSY_ENDS_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> done_o); // R2

    AST_PULSE_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        pulses_o <= CNT_W'(MAX_PULSES)); // R3

    AST_START_WITH_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_pull_o) |-> (!scl_pull_o && !$past(scl_pull_o))); // R5

    AST_SUCCESS_LINES: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !fail_o) |-> (sda_pull_o && !scl_pull_o)); // R5

    AST_RELEASE_SDA_UNDER_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sda_pull_o) |-> (scl_pull_o && $past(scl_pull_o))); // R6

    AST_FAIL_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        fail_o |-> (!scl_pull_o && !sda_pull_o)); // R7

    AST_FAIL_AT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && fail_o) |-> (pulses_o == CNT_W'(MAX_PULSES))); // R7

    AST_LOW_PHASE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(scl_pull_o) |-> (lo_run >= 16'(HALF_DIV))); // R8

    AST_HIGH_PHASE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(scl_pull_o) && $past(busy_o)) |-> (hi_run >= 16'(HALF_DIV))); // R8

endmodule

bind twi_bus_recover twr_checks #(
    .HALF_DIV   (HALF_DIV),
    .MAX_PULSES (MAX_PULSES),
    .CNT_W      (CNT_W)
) u_twr_checks (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_pull_o (scl_pull_o),
    .sda_pull_o (sda_pull_o),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .fail_o     (fail_o),
    .pulses_o   (pulses_o)
);

// File: tb/twi_bus_recover_test.sv
module twi_bus_recover_test;

    localparam int HALF = 4;
    localparam int MAXP = 9;
    localparam int SYNC = 2;
    localparam int CW   = $clog2(MAXP + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req = 1'b0;
    always #2 clk = ~clk;

    logic scl_pull, sda_pull, busy, done, fail;
    logic [CW-1:0] pulses;
    logic stretch;
    logic slave_hold;

    wire scl_line = !scl_pull && !stretch;
    wire sda_line = !sda_pull && !slave_hold;

    twi_bus_recover #(
        .HALF_DIV    (HALF),
        .MAX_PULSES  (MAXP),
        .SYNC_STAGES (SYNC),
        .CNT_W       (CW)
    ) uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .recover_req_i (req),
        .scl_in_i      (scl_line),
        .sda_in_i      (sda_line),
        .scl_pull_o    (scl_pull),
        .sda_pull_o    (sda_pull),
        .busy_o        (busy),
        .done_o        (done),
        .fail_o        (fail),
        .pulses_o      (pulses)
    );

    int n_checks = 0;
    int n_fail   = 0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Slave model: holds SDA until it has seen hold_k falling edges after a pulse.
    int hold_k = 0;
    bit armed  = 1'b0;
    bit active = 1'b0;
    int rise_cnt = 0;
    int fall_cnt = 0;

    assign slave_hold = active && (fall_cnt < hold_k);

    always @(posedge scl_line) rise_cnt++;
    always @(negedge scl_line) begin
        if (armed) begin
            active = 1'b1;
            if (rise_cnt > 0) fall_cnt++;
        end
    end

    // Clock stretching: line stays low stretch_len cycles after release.
    int stretch_len  = 0;
    int stretch_left = 0;
    always @(negedge clk) begin
        if (scl_pull === 1'b1) stretch_left = stretch_len;
        else if (stretch_left > 0) stretch_left--;
    end
    assign stretch = (stretch_left != 0);

    // Line monitor.
    bit p_scl = 1'b1, p_sda = 1'b1;
    int run_len = 0;
    int min_hi = 1000, min_lo = 1000;
    int starts = 0, stops = 0, dones = 0;
    bit mon_on = 1'b0;

    always @(negedge clk) begin
        if (mon_on) begin
            if (scl_line == p_scl) begin
                run_len++;
            end else begin
                if (scl_line && run_len < min_lo) min_lo = run_len;
                if (!scl_line && rise_cnt > 0 && run_len < min_hi) min_hi = run_len;
                run_len = 1;
            end
            if (scl_line && p_scl) begin
                if (p_sda && !sda_line) starts++;
                if (!p_sda && sda_line) stops++;
            end
            if (done) dones++;
        end
        p_scl = scl_line;
        p_sda = sda_line;
    end

    function automatic int exp_pulses(input int k);
        return (k + 1 > MAXP) ? MAXP : k + 1;
    endfunction

    function automatic bit exp_failed(input int k);
        return (k + 1 > MAXP);
    endfunction

    task automatic run_case(input int k, input int s, input bit mid);
        int cyc;
        int ep;
        bit ef;
        bit held;
        ep = exp_pulses(k);
        ef = exp_failed(k);
        armed  = 1'b0;
        active = 1'b0;
        repeat (2) @(posedge clk);
        hold_k = k;
        stretch_len = s;
        rise_cnt = 0;
        fall_cnt = 0;
        starts = 0;
        stops = 0;
        dones = 0;
        min_hi = 1000;
        min_lo = 1000;
        run_len = 0;
        mon_on = 1'b1;
        armed = 1'b1;
        @(negedge clk);
        held = sda_pull;
        req = 1'b1;
        @(negedge clk);
        req = 1'b0;
        check(busy == 1'b1, "R2 busy after request", busy, 1);
        check(scl_pull == 1'b1 && sda_pull == held, "R10 clock pulled before data release",
              {scl_pull, sda_pull}, {1'b1, held});
        check(fail == 1'b0, "R12 fail cleared on new request", fail, 0);
        cyc = 0;
        while (!done && cyc < 20000) begin
            @(negedge clk);
            cyc++;
            req = (mid && cyc == 15 && !done);
        end
        req = 1'b0;
        check(done == 1'b1, "R2 done seen", done, 1);
        check(busy == 1'b0, "R2 busy low with done", busy, 0);
        check(rise_cnt == ep, ef ? "R3 SCL rising edges at limit" : "R4 SCL rising edges", rise_cnt, ep);
        check(int'(pulses) == ep, "R4 pulses_o count", pulses, ep);
        check(fail == ef, "R7 fail flag", fail, ef);
        if (s > 0) check(rise_cnt == ep, "R9 pulse count with stretching", rise_cnt, ep);
        @(negedge clk);
        check(done == 1'b0, "R2 done one cycle", done, 0);
        check(scl_pull == 1'b0, "R5 clock released at end", scl_pull, 0);
        check(sda_pull == !ef, ef ? "R7 data released on fail" : "R5 data held low after START",
              sda_pull, !ef);
        check(starts == (ef ? 0 : 1), "R5 START count", starts, ef ? 0 : 1);
        check(stops == 0, "R6 no STOP generated", stops, 0);
        check(min_lo >= HALF + s, "R8 R9 low phase length", min_lo, HALF + s);
        check(min_hi >= HALF, "R8 high phase length", min_hi, HALF);
        repeat (6) @(posedge clk);
        @(negedge clk);
        check(dones == 1, mid ? "R11 single done with extra request" : "R2 single done", dones, 1);
        check(busy == 1'b0, "R11 no restart from extra request", busy, 0);
        check(fail == ef, "R12 fail held", fail, ef);
        check(int'(pulses) == ep, "R12 pulses held", pulses, ep);
        check(sda_pull == !ef && scl_pull == 1'b0, "R10 line state held in idle",
              {scl_pull, sda_pull}, {1'b0, !ef});
        mon_on = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd2718));
        repeat (3) @(negedge clk);
        check(scl_pull == 1'b0 && sda_pull == 1'b0, "R1 lines released in reset",
              {scl_pull, sda_pull}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(scl_pull == 1'b0 && sda_pull == 1'b0, "R1 lines released after reset",
              {scl_pull, sda_pull}, 0);
        check({busy, done, fail} == 3'b000, "R1 status idle after reset", {busy, done, fail}, 0);
        check(pulses == '0, "R1 pulses zero after reset", pulses, 0);

        run_case(0, 0, 1'b0);
        run_case(8, 0, 1'b0);
        run_case(9, 0, 1'b0);
        run_case(3, 0, 1'b0);
        run_case(30, 3, 1'b1);
        run_case(2, 7, 1'b1);
        run_case(8, 5, 1'b0);
        for (int i = 0; i < 24; i++) begin
            int k;
            int s;
            bit m;
            k = int'($urandom_range(0, 11));
            s = int'($urandom_range(0, 5));
            m = 1'($urandom_range(0, 1));
            run_case(k, s, m);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule